// File: doc/BRIEF.md
# Bus Ready and System Reset Synchronizer

This block produces the two control signals a processor needs from its clock generator. One is a wait-state control (READY) and the other is a system reset, and both are aligned to the processor clock. Two bus-ready sources each come with an active-low enable. A source counts as finished only while its enable is low and its ready line is high. The qualified requests from all sources are ORed together and passed through a multi-flop synchronizer, so READY follows the bus condition a fixed number of clock edges later.

The reset request is active-low and may change at any time. In the default mode it asserts the system reset at once, without waiting for a clock edge. Release is synchronous: the system reset falls only after the released request has passed through the same number of flops. While the system reset is high, READY is forced low. The number of sources, the synchronizer depth and the reset-assertion mode are all parameters.

Top module: `bus_ready_reset_gen`

## Requirements
- R1: Source i is qualified only while `src_en_n_i[i]` is 0 and `src_rdy_i[i]` is 1. A ready line whose enable is 1 has no effect on `ready_o`.
- R2: The qualified requests of all sources are ORed, so either enabled source alone can raise `ready_o`.
- R3: A change of the merged request reaches `ready_o` on the SYNC_STAGES-th rising clock edge after it (2 by default) and not earlier.
- R4: `ready_o` is 0 whenever every enable input is 1, whatever the ready inputs are.
- R5: While `rst_req_n_i` is 0, `sys_reset_o` is 1. In the default asynchronous-assert mode (RST_MODE = RST_ASSERT_ASYNC) it rises without waiting for a clock edge.
- R6: After `rst_req_n_i` returns to 1, `sys_reset_o` falls on the SYNC_STAGES-th rising edge and stays high before that edge.
- R7: `sys_reset_o` is 1 from power-up, before any clock edge has occurred, provided the reset request is held low.
- R8: `ready_o` is 0 whenever `sys_reset_o` is 1.
- R9: In the default mode, a reset-request pulse shorter than one clock period that falls between two clock edges still asserts `sys_reset_o`. After such a pulse the system reset is held for the full release latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock |
| rst_req_n_i | input | 1 | Asynchronous reset request, active low |
| src_en_n_i | input | N_SRC | Per-source enable, active low |
| src_rdy_i | input | N_SRC | Per-source bus-ready, high means transfer done |
| ready_o | output | 1 | Synchronized merged ready |
| sys_reset_o | output | 1 | Synchronized system reset, active high |

## Verification
On every cycle, the assertions check several properties. READY is never high during system reset. READY settles low once the merged request has been low for the full synchronizer depth, and settles high once it has been high for that depth. The reset output follows the request while the request is low, and it never falls unless the request was already released at the previous edge. Other behaviours only the bench scenarios can show. These are the exact edge on which each change lands, the result of every enable and ready combination, power-up before the first edge, and a reset pulse narrower than a clock period.

// File: rtl/brrg_pkg.sv
package brrg_pkg;

   // how the system reset is asserted
   typedef enum logic {
      RST_ASSERT_SYNC  = 1'b0,
      RST_ASSERT_ASYNC = 1'b1
   } rst_mode_e;

   // clear style of a synchronizer chain
   typedef enum logic [1:0] {
      CLR_NONE  = 2'd0,
      CLR_SYNC  = 2'd1,
      CLR_ASYNC = 2'd2
   } clr_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_SRC         = 16;

endpackage

// File: rtl/brrg_qualify.sv
module brrg_qualify #(
   parameter int unsigned N_SRC = 2
) (
   input  logic [N_SRC-1:0] en_n_i,
   input  logic [N_SRC-1:0] rdy_i,
   output logic [N_SRC-1:0] qual_o,
   output logic             any_o
);

   if (N_SRC < 1 || N_SRC > brrg_pkg::MAX_SRC) begin : g_bad_nsrc
      $error("brrg_qualify: N_SRC out of range");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign qual_o[i] = ~en_n_i[i] & rdy_i[i];
   end

   assign any_o = |qual_o;

endmodule

// File: rtl/brrg_sync_chain.sv
module brrg_sync_chain #(
   parameter int unsigned         WIDTH    = 1,
   parameter int unsigned         STAGES   = 2,
   parameter brrg_pkg::clr_mode_e CLR_MODE = brrg_pkg::CLR_NONE
) (
   input  logic             clk_i,
   input  logic             clr_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < brrg_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("brrg_sync_chain: STAGES below minimum");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("brrg_sync_chain: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   if (CLR_MODE == brrg_pkg::CLR_ASYNC) begin : g_async
      always_ff @(posedge clk_i or negedge clr_n_i) begin
         if (!clr_n_i) begin
            stg_q <= '0;
         end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
         end
      end
   end else if (CLR_MODE == brrg_pkg::CLR_SYNC) begin : g_sync
      always_ff @(posedge clk_i) begin
         if (!clr_n_i) begin
            stg_q <= '0;
         end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
         end
      end
   end else begin : g_none
      logic unused_clr;
      assign unused_clr = clr_n_i;
      always_ff @(posedge clk_i) begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[LAST];

endmodule

// File: rtl/bus_ready_reset_gen.sv
module bus_ready_reset_gen #(
   parameter int unsigned         N_SRC       = 2,
   parameter int unsigned         SYNC_STAGES = 2,
   parameter brrg_pkg::rst_mode_e RST_MODE    = brrg_pkg::RST_ASSERT_ASYNC
) (
   input  logic             clk_i,
   input  logic             rst_req_n_i,
   input  logic [N_SRC-1:0] src_en_n_i,
   input  logic [N_SRC-1:0] src_rdy_i,
   output logic             ready_o,
   output logic             sys_reset_o
);

   localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SYNC_STAGES);

   if (SYNC_STAGES < brrg_pkg::MIN_SYNC_STAGES) begin : g_bad_depth
      $error("bus_ready_reset_gen: SYNC_STAGES below minimum");
   end

   // ---------------- ready path ----------------
   logic [N_SRC-1:0] qual;
   logic             any_qual;
   logic             rdy_sync;

   brrg_qualify #(
      .N_SRC (N_SRC)
   ) qual_i (
      .en_n_i (src_en_n_i),
      .rdy_i  (src_rdy_i),
      .qual_o (qual),
      .any_o  (any_qual)
   );

   brrg_sync_chain #(
      .WIDTH    (1),
      .STAGES   (SYNC_STAGES),
      .CLR_MODE (brrg_pkg::CLR_NONE)
   ) rdy_sync_i (
      .clk_i   (clk_i),
      .clr_n_i (1'b1),
      .d_i     (any_qual),
      .q_o     (rdy_sync)
   );

   // ---------------- reset path ----------------
   // chain carries "released" bits; output is its inverse
   logic rst_released;

   if (RST_MODE == brrg_pkg::RST_ASSERT_ASYNC) begin : g_rst_async
      brrg_sync_chain #(
         .WIDTH    (1),
         .STAGES   (SYNC_STAGES),
         .CLR_MODE (brrg_pkg::CLR_ASYNC)
      ) rst_sync_i (
         .clk_i   (clk_i),
         .clr_n_i (rst_req_n_i),
         .d_i     (1'b1),
         .q_o     (rst_released)
      );
   end else begin : g_rst_sync
      brrg_sync_chain #(
         .WIDTH    (1),
         .STAGES   (SYNC_STAGES),
         .CLR_MODE (brrg_pkg::CLR_NONE)
      ) rst_sync_i (
         .clk_i   (clk_i),
         .clr_n_i (1'b1),
         .d_i     (rst_req_n_i),
         .q_o     (rst_released)
      );
   end

   assign sys_reset_o = ~rst_released;
   assign ready_o     = rdy_sync & rst_released;

   // ---------------- assertion support counters ----------------
   logic [CNT_W-1:0] idle_cnt;
   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk_i or negedge rst_req_n_i) begin
      if (!rst_req_n_i) begin
         idle_cnt <= '0;
         busy_cnt <= '0;
      end else begin
         idle_cnt <= any_qual ? '0 : ((idle_cnt == CNT_SAT) ? idle_cnt : idle_cnt + 1'b1);
         busy_cnt <= !any_qual ? '0 : ((busy_cnt == CNT_SAT) ? busy_cnt : busy_cnt + 1'b1);
      end
   end

   // R8
   ready_low_in_reset_chk: assert property (@(posedge clk_i)
      disable iff (!rst_req_n_i) sys_reset_o |-> !ready_o);

   // R3 R4
   ready_settles_low_chk: assert property (@(posedge clk_i)
      disable iff (!rst_req_n_i) (idle_cnt == CNT_SAT) |-> !ready_o);

   // R2 R3
   ready_settles_high_chk: assert property (@(posedge clk_i)
      disable iff (!rst_req_n_i) (busy_cnt == CNT_SAT && !sys_reset_o) |-> ready_o);

   // R6
   reset_release_order_chk: assert property (@(posedge clk_i)
      disable iff (!rst_req_n_i) $fell(sys_reset_o) |-> $past(rst_req_n_i));

   if (RST_MODE == brrg_pkg::RST_ASSERT_ASYNC) begin : g_async_chk
      // R5
      reset_follows_req_chk: assert property (@(posedge clk_i)
         disable iff (rst_req_n_i) 1'b1 |-> sys_reset_o);
   end

endmodule

// File: tb/bus_ready_reset_gen_tb_top.sv
`timescale 1ns/1ps
module bus_ready_reset_gen_tb_top;

   localparam int unsigned N_SRC = 2;

   logic             clk_i = 1'b0;
   logic             rst_req_n_i;
   logic [N_SRC-1:0] src_en_n_i;
   logic [N_SRC-1:0] src_rdy_i;
   logic             ready_o;
   logic             sys_reset_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk_i = ~clk_i;

   bus_ready_reset_gen #(
      .N_SRC       (N_SRC),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk_i       (clk_i),
      .rst_req_n_i (rst_req_n_i),
      .src_en_n_i  (src_en_n_i),
      .src_rdy_i   (src_rdy_i),
      .ready_o     (ready_o),
      .sys_reset_o (sys_reset_o)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic merged(input logic [N_SRC-1:0] en_n, input logic [N_SRC-1:0] rdy);
      logic r = 1'b0;
      for (int i = 0; i < N_SRC; i++) r = r | (!en_n[i] && rdy[i]);
      return r;
   endfunction

   function automatic string tag_for(input logic [N_SRC-1:0] en_n);
      if (en_n == '1) return "R4";
      if ($countones(~en_n) == 1) return "R1";
      return "R2";
   endfunction

   task automatic sweep(input bit reverse);
      logic prev;
      prev = ready_o;
      for (int k = 0; k < 16; k++) begin
         int v;
         logic [N_SRC-1:0] en_n, rdy;
         logic exp;
         v = reverse ? (15 - k) : k;
         en_n = v[3:2];
         rdy  = v[1:0];
         exp  = merged(en_n, rdy);
         src_en_n_i = en_n;
         src_rdy_i  = rdy;
         @(negedge clk_i);
         chk("R3", "ready holds for one edge", ready_o, prev);
         @(negedge clk_i);
         chk(tag_for(en_n), "ready after two edges", ready_o, exp);
         prev = exp;
      end
   endtask

   initial begin
      rst_req_n_i = 1'b0;
      src_en_n_i  = 2'b00;
      src_rdy_i   = 2'b11;
      #1;
      chk("R7", "reset at power-up", sys_reset_o, 1'b1);
      chk("R8", "ready low at power-up", ready_o, 1'b0);
      repeat (3) @(negedge clk_i);
      chk("R5", "reset held while requested", sys_reset_o, 1'b1);
      chk("R8", "ready low while in reset", ready_o, 1'b0);

      // release
      rst_req_n_i = 1'b1;
      @(negedge clk_i);
      chk("R6", "reset still high after one edge", sys_reset_o, 1'b1);
      chk("R8", "ready low after one edge", ready_o, 1'b0);
      @(negedge clk_i);
      chk("R6", "reset low after two edges", sys_reset_o, 1'b0);
      chk("R8", "ready high after release", ready_o, 1'b1);

      // exhaustive sweeps, both orders
      sweep(1'b0);
      sweep(1'b1);

      // asynchronous assertion between edges
      src_en_n_i = 2'b10;
      src_rdy_i  = 2'b01;
      repeat (2) @(negedge clk_i);
      chk("R1", "source 0 alone qualified", ready_o, 1'b1);
      #0.5 rst_req_n_i = 1'b0;
      #0.5;
      chk("R5", "reset rises without edge", sys_reset_o, 1'b1);
      chk("R8", "ready drops with reset", ready_o, 1'b0);
      repeat (2) @(negedge clk_i);
      rst_req_n_i = 1'b1;
      @(negedge clk_i);
      chk("R6", "reset held one edge after release", sys_reset_o, 1'b1);
      @(negedge clk_i);
      chk("R6", "reset falls on second edge", sys_reset_o, 1'b0);

      // narrow pulse between edges
      #0.5 rst_req_n_i = 1'b0;
      #0.5 rst_req_n_i = 1'b1;
      #0.5;
      chk("R9", "narrow pulse captured", sys_reset_o, 1'b1);
      @(negedge clk_i);
      chk("R9", "narrow pulse held one edge", sys_reset_o, 1'b1);
      chk("R8", "ready low after narrow pulse", ready_o, 1'b0);
      @(negedge clk_i);
      chk("R9", "narrow pulse released", sys_reset_o, 1'b0);
      chk("R2", "ready back after narrow pulse", ready_o, 1'b1);

      // disabled sources ignored
      src_en_n_i = 2'b11;
      src_rdy_i  = 2'b11;
      repeat (2) @(negedge clk_i);
      chk("R4", "all disabled keeps ready low", ready_o, 1'b0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100us;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule